// File: doc/BRIEF.md
# Long-Cable JTAG Response Capture Buffer

This block sits next to the devices under test at the far end of a long boundary-scan cable. Over a long cable, the response bit can return to the controller half a clock period late or more. The controller therefore never samples it directly. Instead, the test clock, mode select and response line that come back over the cable are re-timed into a local system clock. A model of the TAP controller follows the returned mode-select line. Every response bit seen while that model is in a shift state is written into a bit FIFO. The timing of this capture comes only from the returned clock, so cable length does not affect it. The local clock must run at least four times faster than the test clock, for example 100 MHz for a 25 MHz test clock over about 50 m.

There are two FIFOs. A pass-start strobe from the host exchanges their roles. One FIFO collects the responses of the current pass. The other FIFO plays back the responses of the previous pass, one bit per falling edge of the host's own test clock. A full scan therefore takes two passes. The first pass applies the real vectors and the host ignores whatever is played back. The second pass is a dummy pass: the host reads the real responses while the dummy responses fill the other FIFO.

Top module: `jtag_resp_capture`

## Requirements
- R1: After reset, `replay_tdo` is 1, `capture_ovf` is 0, and the TAP model is in Test-Logic-Reset. Returned clock edges that keep the TAP model out of the shift states store no bits.
- R2: The TAP model changes state only on a rising edge of the returned TCK. It moves along the standard 16-state diagram according to the returned TMS level, and five consecutive edges with TMS high bring it to Test-Logic-Reset from any state.
- R3: On each rising edge of the returned TCK while the TAP model is in Shift-DR or Shift-IR, exactly one bit is stored: the returned TDO level at that edge. Edges in any other state, including the pause states, store nothing.
- R4: A one-cycle `pass_start` pulse exchanges the roles of the two FIFOs. Playback then starts at the first bit captured during the pass that just ended.
- R5: At the exchange, the FIFO that now takes captures is emptied. Nothing from its earlier contents can be played back afterwards.
- R6: `replay_tdo` presents the stored bits in capture order. Each falling edge of `host_tck` advances playback by one bit. `host_tck` idles high.
- R7: Once playback has gone past the number of stored bits, and when the playback FIFO is empty, `replay_tdo` is 1.
- R8: A FIFO holds DEPTH bits (1024 by default). Shift-state bits that arrive when it is full are dropped and set `capture_ovf`. The flag stays set until the next `pass_start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock, at least 4x the TCK rate |
| rst | input | 1 | Synchronous active-high reset |
| ret_tck | input | 1 | Test clock as returned from the far end of the cable |
| ret_tms | input | 1 | Mode select as returned from the far end |
| ret_tdo | input | 1 | Response data from the devices under test |
| pass_start | input | 1 | One-cycle strobe in the clk domain that starts a new scan pass |
| host_tck | input | 1 | Host-side test clock that paces playback |
| replay_tdo | output | 1 | Played-back response bit for the host |
| capture_ovf | output | 1 | Sticky flag: capture FIFO was full when a bit arrived |

## Verification
The hardest case to reach from the ports is a TAP walk that leaves the shift state, stays in Pause-DR while the response line toggles, and then comes back through Exit2 into Shift-DR. Only the edges that occur in a shift state may appear in the playback. The bench drives complete TMS walks cycle by cycle for this detour. It drives a separate walk in which five TMS-high edges leave Shift-DR and return to Test-Logic-Reset. A reduced DEPTH lets the bench overfill a FIFO in one scan, which checks the overflow flag and confirms that playback stops at DEPTH bits.

// File: rtl/jrc_pkg.sv
package jrc_pkg;

  typedef enum logic [3:0] {
    TAP_TLR      = 4'd0,
    TAP_IDLE     = 4'd1,
    TAP_DR_SEL   = 4'd2,
    TAP_DR_CAP   = 4'd3,
    TAP_DR_SHIFT = 4'd4,
    TAP_DR_EX1   = 4'd5,
    TAP_DR_PAUSE = 4'd6,
    TAP_DR_EX2   = 4'd7,
    TAP_DR_UPD   = 4'd8,
    TAP_IR_SEL   = 4'd9,
    TAP_IR_CAP   = 4'd10,
    TAP_IR_SHIFT = 4'd11,
    TAP_IR_EX1   = 4'd12,
    TAP_IR_PAUSE = 4'd13,
    TAP_IR_EX2   = 4'd14,
    TAP_IR_UPD   = 4'd15
  } tap_state_e;

endpackage

// File: rtl/jrc_sync.sv
module jrc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jrc_tap.sv
module jrc_tap
  import jrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       tms,
  output tap_state_e state,
  output logic       shifting
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TAP_TLR:      nxt = tms ? TAP_TLR      : TAP_IDLE;
      TAP_IDLE:     nxt = tms ? TAP_DR_SEL   : TAP_IDLE;
      TAP_DR_SEL:   nxt = tms ? TAP_IR_SEL   : TAP_DR_CAP;
      TAP_DR_CAP:   nxt = tms ? TAP_DR_EX1   : TAP_DR_SHIFT;
      TAP_DR_SHIFT: nxt = tms ? TAP_DR_EX1   : TAP_DR_SHIFT;
      TAP_DR_EX1:   nxt = tms ? TAP_DR_UPD   : TAP_DR_PAUSE;
      TAP_DR_PAUSE: nxt = tms ? TAP_DR_EX2   : TAP_DR_PAUSE;
      TAP_DR_EX2:   nxt = tms ? TAP_DR_UPD   : TAP_DR_SHIFT;
      TAP_DR_UPD:   nxt = tms ? TAP_DR_SEL   : TAP_IDLE;
      TAP_IR_SEL:   nxt = tms ? TAP_TLR      : TAP_IR_CAP;
      TAP_IR_CAP:   nxt = tms ? TAP_IR_EX1   : TAP_IR_SHIFT;
      TAP_IR_SHIFT: nxt = tms ? TAP_IR_EX1   : TAP_IR_SHIFT;
      TAP_IR_EX1:   nxt = tms ? TAP_IR_UPD   : TAP_IR_PAUSE;
      TAP_IR_PAUSE: nxt = tms ? TAP_IR_EX2   : TAP_IR_PAUSE;
      TAP_IR_EX2:   nxt = tms ? TAP_IR_UPD   : TAP_IR_SHIFT;
      TAP_IR_UPD:   nxt = tms ? TAP_DR_SEL   : TAP_IDLE;
      default:      nxt = TAP_TLR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= TAP_TLR;
    else if (step) state <= nxt;
  end

  assign shifting = (state == TAP_DR_SHIFT) || (state == TAP_IR_SHIFT);

  // R2: no returned clock edge, no movement
  a_r2_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
  // R2: TMS high in Test-Logic-Reset keeps the model there
  a_r2_tlr_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == TAP_TLR && step && tms) |=> state == TAP_TLR);
endmodule

// File: rtl/jrc_bitram.sv
module jrc_bitram #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/jrc_fifo_pair.sv
module jrc_fifo_pair #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic swap,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_adv,
  output logic rd_bit,
  output logic ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          wsel;
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] rd_ptr;
  logic          sel_q, valid_q;
  logic [1:0]    bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel   <= 1'b0;
      cnt[0] <= '0;
      cnt[1] <= '0;
      rd_ptr <= '0;
      ovf    <= 1'b0;
    end else if (swap) begin
      wsel       <= ~wsel;
      cnt[~wsel] <= '0;
      rd_ptr     <= '0;
      ovf        <= 1'b0;
    end else begin
      if (wr_en) begin
        if (cnt[wsel] == FULL) ovf <= 1'b1;
        else                   cnt[wsel] <= cnt[wsel] + 1'b1;
      end
      if (rd_adv && rd_ptr != FULL) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && !swap && (wsel == 1'(b)) && (cnt[b] != FULL);
    jrc_bitram #(.DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (bank_we),
      .waddr (cnt[b][AW-1:0]),
      .wdata (wr_bit),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b1;
      valid_q <= 1'b0;
      rd_bit  <= 1'b1;
    end else begin
      sel_q   <= ~wsel;
      valid_q <= rd_ptr < cnt[~wsel];
      rd_bit  <= valid_q ? bank_q[sel_q] : 1'b1;
    end
  end

  // R8: the flag persists until a swap
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !swap) |=> ovf);
  // R8: fill level never exceeds the depth
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt[wsel] <= FULL);
  // R5: the FIFO taking captures after a swap starts empty
  a_r5_refill_empty: assert property (@(posedge clk) disable iff (rst)
    swap |=> cnt[wsel] == '0);
  // R4: playback restarts at the first bit
  a_r4_rd_home: assert property (@(posedge clk) disable iff (rst)
    swap |=> rd_ptr == '0);
  // R7: outside the stored range the output is 1
  a_r7_past_end_one: assert property (@(posedge clk) disable iff (rst)
    !valid_q |=> rd_bit);
endmodule

// File: rtl/jtag_resp_capture.sv
module jtag_resp_capture
  import jrc_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ret_tck,
  input  logic ret_tms,
  input  logic ret_tdo,
  input  logic pass_start,
  input  logic host_tck,
  output logic replay_tdo,
  output logic capture_ovf
);
  logic [3:0] s_in;
  logic       tck_q, htck_q;
  logic       tck_rise, htck_fall;
  tap_state_e tap_state;
  logic       shifting;

  jrc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_tck, ret_tck, ret_tms, ret_tdo}),
    .q   (s_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tck_q  <= 1'b0;
      htck_q <= 1'b1;
    end else begin
      tck_q  <= s_in[2];
      htck_q <= s_in[3];
    end
  end

  assign tck_rise  = s_in[2] & ~tck_q;
  assign htck_fall = ~s_in[3] & htck_q;

  jrc_tap u_tap (
    .clk      (clk),
    .rst      (rst),
    .step     (tck_rise),
    .tms      (s_in[1]),
    .state    (tap_state),
    .shifting (shifting)
  );

  jrc_fifo_pair #(.DEPTH(DEPTH)) u_fifos (
    .clk    (clk),
    .rst    (rst),
    .swap   (pass_start),
    .wr_en  (tck_rise & shifting),
    .wr_bit (s_in[0]),
    .rd_adv (htck_fall),
    .rd_bit (replay_tdo),
    .ovf    (capture_ovf)
  );

  // R3: a stored bit always comes from a shift state
  a_r3_capture_in_shift: assert property (@(posedge clk) disable iff (rst)
    (tck_rise && !shifting) |=> !capture_ovf || $past(capture_ovf));
  // R1: the TAP model leaves reset only on a returned edge
  a_r1_tlr_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (tap_state == TAP_TLR && !tck_rise) |=> tap_state == TAP_TLR);
endmodule

// File: tb/jtag_resp_capture_tb.sv
module jtag_resp_capture_tb;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ret_tck = 1'b0, ret_tms = 1'b1, ret_tdo = 1'b0;
  logic pass_start = 1'b0, host_tck = 1'b1;
  logic replay_tdo, capture_ovf;

  int checks = 0, failures = 0;
  bit done = 0;
  bit cap_q[$];
  bit rep_q[$];

  always #10 clk = ~clk;

  jtag_resp_capture #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ret_tck(ret_tck), .ret_tms(ret_tms),
    .ret_tdo(ret_tdo), .pass_start(pass_start), .host_tck(host_tck),
    .replay_tdo(replay_tdo), .capture_ovf(capture_ovf)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one returned TCK period; the bit is captured only if cap is set
  task automatic edge1(input logic tms, input logic tdo, input bit cap);
    ret_tms = tms; ret_tdo = tdo; ret_tck = 1'b0;
    wclk(4);
    ret_tck = 1'b1;
    wclk(4);
    ret_tck = 1'b0;
    if (cap) cap_q.push_back(tdo);
  endtask

  // from Run-Test/Idle through a full DR or IR scan and back
  task automatic scan(input bit ir, input int n, input logic [63:0] pat);
    edge1(1, 0, 0);
    if (ir) edge1(1, 1, 0);
    edge1(0, 1, 0);
    edge1(0, 1, 0);
    for (int i = 0; i < n; i++) edge1(i == n - 1, pat[i], 1);
    edge1(1, 1, 0);
    edge1(0, 1, 0);
  endtask

  task automatic new_pass();
    wclk(4);
    pass_start = 1'b1;
    wclk(1);
    pass_start = 1'b0;
    rep_q = cap_q;
    cap_q = {};
  endtask

  task automatic replay(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      wclk(8);
      chk(req, replay_tdo, (i < rep_q.size()) ? rep_q[i] : 1'b1);
      host_tck = 1'b0;
      wclk(4);
      host_tck = 1'b1;
    end
  endtask

  initial begin
    wclk(3);
    rst = 1'b0;
    wclk(1);
    // R1: reset state
    chk("R1 replay", replay_tdo, 1'b1);
    chk("R1 ovf", capture_ovf, 1'b0);
    // R1: edges in Test-Logic-Reset and Idle store nothing
    edge1(1, 0, 0); edge1(1, 0, 0); edge1(0, 0, 0); edge1(0, 0, 0);
    new_pass();
    replay("R1 idle edges", 3);
    // R3/R4/R6/R7: DR then IR scan, played back in the next pass
    scan(0, 10, 64'h2D3);
    scan(1, 6, 64'h15);
    chk("R8 no ovf", capture_ovf, 1'b0);
    new_pass();
    // R3: pause detour, toggling TDO that must not be stored
    edge1(1, 0, 0); edge1(0, 0, 0); edge1(0, 0, 0);
    edge1(0, 1, 1); edge1(0, 0, 1); edge1(1, 1, 1);
    edge1(0, 0, 0); edge1(0, 1, 0); edge1(1, 0, 0);
    edge1(0, 1, 0);
    edge1(0, 0, 1); edge1(1, 1, 1);
    edge1(1, 0, 0); edge1(0, 0, 0);
    replay("R6 order", 18);
    new_pass();
    replay("R3 pause", 7);
    // R5: swap twice with no captures in between
    new_pass();
    new_pass();
    replay("R5 cleared", 3);
    // R2: five TMS-high edges out of Shift-DR reach Test-Logic-Reset
    edge1(1, 0, 0); edge1(0, 0, 0); edge1(0, 0, 0);
    edge1(0, 1, 1); edge1(0, 0, 1); edge1(1, 1, 1);
    edge1(1, 0, 0); edge1(1, 0, 0); edge1(1, 0, 0); edge1(1, 0, 0);
    edge1(0, 0, 0);
    scan(0, 4, 64'h9);
    new_pass();
    replay("R2 reset walk", 8);
    // R8: overfill one FIFO
    new_pass();
    scan(0, 40, 64'hA5C3_F0F0_1234);
    wclk(4);
    chk("R8 ovf set", capture_ovf, 1'b1);
    wclk(20);
    chk("R8 ovf held", capture_ovf, 1'b1);
    new_pass();
    while (rep_q.size() > DEPTH) void'(rep_q.pop_back());
    wclk(2);
    chk("R8 ovf cleared", capture_ovf, 1'b0);
    replay("R8 truncated", DEPTH + 2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule